// File: doc/BRIEF.md
# NAND Bank Strobe Decoder

This block turns byte writes from a host into bus cycles on an 8-bit NAND flash interface. The host writes into a bank window. Two high address bits inside that window decide whether the byte goes out as a command, an address or a data byte. The block then drives the command-latch and address-latch strobes together with the data byte. It frames a write-enable pulse with one setup clock and one hold clock. The length of the pulse is set by an input.

A chip-control register holds two bits per chip. Bit 2n enables chip n and bit 2n+1 selects it. The active-low chip-enable of chip n goes low only when both of its bits are 1. Host reads of the bank return the flash data bus directly. A ready/busy pin from the flash passes through a two-flop synchronizer and is offered to the host as a ready flag.

Top module: `nand_strobe_ctl`

## Requirements
- R1: A bank write with address bit AW-1 set (offset 0x10000 by default) is an address cycle: ALE is 1 and CLE is 0 for its whole frame.
- R2: A bank write with bit AW-2 set and bit AW-1 clear (offset 0x08000) is a command cycle: CLE is 1 and ALE is 0 for its whole frame.
- R3: A bank write with both of those bits clear is a data cycle, and CLE and ALE both stay 0.
- R4: CLE and ALE are never 1 in the same cycle. A write with both decode bits set is treated as an address cycle.
- R5: In the chip-control register, bit 2n enables chip n and bit 2n+1 asserts it. nand_ce_n[n] is 0 exactly when both bits are 1, one cycle after the register write.
- R6: The chip-control register resets to 0. Writing 0 to it drives every nand_ce_n bit to 1 on the next cycle.
- R7: An accepted write gives one setup clock with nand_we_n high, then strobe_len clocks with nand_we_n low (a value of 0 counts as 1), then one hold clock. nand_dq_oe is high for the whole frame, and CLE, ALE and nand_dout do not change during it. The frame starts the cycle after the write is accepted.
- R8: host_busy is 1 for the whole frame. A bank write is accepted only while host_busy is 0, and a write presented during a frame has no effect.
- R9: host_ready equals nand_rb as it was two clocks earlier (two-flop synchronizer, reset to 0).
- R10: bank_rdata always equals nand_din, one byte wide, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_wr | input | 1 | Host write strobe into the bank window |
| bank_addr | input | AW | Offset inside the bank window |
| bank_wdata | input | 8 | Byte to be sent to the flash |
| bank_rdata | output | 8 | Byte read from the flash bus |
| strobe_len | input | LW | Number of clocks nand_we_n stays low |
| ctl_wr | input | 1 | Write strobe for the chip-control register |
| ctl_wdata | input | 2*NCHIP | New value for the chip-control register |
| ctl_q | output | 2*NCHIP | Current value of the chip-control register |
| host_busy | output | 1 | A write frame is in progress |
| host_ready | output | 1 | Synchronized flash ready flag |
| nand_din | input | 8 | Flash data bus, input side |
| nand_dout | output | 8 | Flash data bus, output side |
| nand_dq_oe | output | 1 | Output enable for the data bus |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write enable |
| nand_ce_n | output | NCHIP | Active-low chip enables |
| nand_rb | input | 1 | Flash ready/busy pin, 1 when ready |

## Verification
Two pairs of events can coincide. A bank write can arrive while a frame is still running, and a chip-control write can land in the middle of a strobe. The bench holds bank_wr high across whole frames and issues register writes during the strobe. A behavioural model, built from per-frame counters, predicts in every cycle whether the write is dropped, what the strobes and enables are, and that chip-enable changes do not disturb the frame. The address-bit collision case, with both decode bits set, is provoked directly and judged against R4.

// File: rtl/nand_strobe_ctl.sv
module nand_strobe_ctl #(
  parameter int NCHIP = 4,
  parameter int AW    = 17,
  parameter int LW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bank_wr,
  input  logic [AW-1:0]        bank_addr,
  input  logic [7:0]           bank_wdata,
  output logic [7:0]           bank_rdata,
  input  logic [LW-1:0]        strobe_len,
  input  logic                 ctl_wr,
  input  logic [2*NCHIP-1:0]   ctl_wdata,
  output logic [2*NCHIP-1:0]   ctl_q,
  output logic                 host_busy,
  output logic                 host_ready,
  input  logic [7:0]           nand_din,
  output logic [7:0]           nand_dout,
  output logic                 nand_dq_oe,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic [NCHIP-1:0]     nand_ce_n,
  input  logic                 nand_rb
);
  localparam int CW = 2 * NCHIP;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t           st;
  logic [LW-1:0] cnt;
  logic [CW-1:0] ctl;
  logic [1:0]    rb_q;
  logic          cle_q, ale_q;
  logic [7:0]    dq_q;

  wire           hit_ale = bank_addr[AW-1];
  wire           hit_cle = bank_addr[AW-2] & ~bank_addr[AW-1];
  wire [LW-1:0]  len_eff = (strobe_len == '0) ? LW'(1) : strobe_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      dq_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (bank_wr) begin
          st    <= S_SETUP;
          ale_q <= hit_ale;
          cle_q <= hit_cle;
          dq_q  <= bank_wdata;
          cnt   <= len_eff - LW'(1);
        end
        S_SETUP: st <= S_STRB;
        S_STRB: begin
          if (cnt == '0) st <= S_HOLD;
          else           cnt <= cnt - LW'(1);
        end
        default: begin
          st    <= S_IDLE;
          cle_q <= 1'b0;
          ale_q <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      rb_q <= '0;
    end else begin
      if (ctl_wr) ctl <= ctl_wdata;
      rb_q <= {rb_q[0], nand_rb};
    end
  end

  assign nand_cle   = cle_q;
  assign nand_ale   = ale_q;
  assign nand_dout  = dq_q;
  assign nand_dq_oe = (st != S_IDLE);
  assign nand_we_n  = (st != S_STRB);
  assign host_busy  = (st != S_IDLE);
  assign host_ready = rb_q[1];
  assign bank_rdata = nand_din;
  assign ctl_q      = ctl;

  for (genvar n = 0; n < NCHIP; n++) begin : g_ce
    assign nand_ce_n[n] = ~(ctl[2*n] & ctl[2*n+1]);
  end
endmodule

// File: rtl/nand_strobe_ctl_chk.sv
module nand_strobe_ctl_chk #(
  parameter int NCHIP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_wr,
  input logic [2*NCHIP-1:0] ctl_wdata,
  input logic               nand_cle,
  input logic               nand_ale,
  input logic               nand_we_n,
  input logic               nand_dq_oe,
  input logic [7:0]         nand_dout,
  input logic [NCHIP-1:0]   nand_ce_n,
  input logic               host_busy,
  input logic               host_ready,
  input logic               nand_rb
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  assert_no_strobe_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_we_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_frame_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0 && nand_dq_oe && $past(nand_dq_oe)) |->
      ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dout)));

  assert_busy_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> host_busy);

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == '0) |=> (&nand_ce_n));

  assert_ready_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (host_ready == $past(nand_rb, 2)));
endmodule

bind nand_strobe_ctl nand_strobe_ctl_chk #(.NCHIP(NCHIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_dq_oe(nand_dq_oe), .nand_dout(nand_dout), .nand_ce_n(nand_ce_n),
  .host_busy(host_busy), .host_ready(host_ready), .nand_rb(nand_rb)
);

// File: tb/nand_strobe_ctl_test.sv
`timescale 1ns/1ps
module nand_strobe_ctl_test;
  localparam int NCHIP = 4, AW = 17, LW = 4;

  logic clk = 0, rst_n = 0;
  logic bank_wr = 0;
  logic [AW-1:0] bank_addr = '0;
  logic [7:0] bank_wdata = '0, bank_rdata, nand_din = '0, nand_dout;
  logic [LW-1:0] strobe_len = '0;
  logic ctl_wr = 0;
  logic [2*NCHIP-1:0] ctl_wdata = '0, ctl_q;
  logic host_busy, host_ready, nand_dq_oe, nand_cle, nand_ale, nand_we_n, nand_rb = 0;
  logic [NCHIP-1:0] nand_ce_n;

  nand_strobe_ctl #(.NCHIP(NCHIP), .AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .strobe_len(strobe_len),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .host_busy(host_busy),
    .host_ready(host_ready), .nand_din(nand_din), .nand_dout(nand_dout),
    .nand_dq_oe(nand_dq_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_ce_n(nand_ce_n), .nand_rb(nand_rb));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_active = 0;
  int m_k = 0, m_len = 1, m_kind = 0;
  int m_data = 0, m_ctl = 0, m_rb1 = 0, m_rb2 = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_k = 0; m_ctl = 0; m_rb1 = 0; m_rb2 = 0;
    end else begin
      if (m_active) begin
        m_k++;
        if (m_k > m_len + 1) m_active = 0;
      end else if (bank_wr) begin
        m_active = 1; m_k = 0;
        m_len  = (strobe_len == 0) ? 1 : int'(strobe_len);
        m_kind = bank_addr[AW-1] ? 2 : (bank_addr[AW-2] ? 1 : 0);
        m_data = int'(bank_wdata);
      end
      if (ctl_wr) m_ctl = int'(ctl_wdata);
      m_rb2 = m_rb1; m_rb1 = int'(nand_rb);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int ce;
    ce = 0;
    for (int n = 0; n < NCHIP; n++)
      if (!(((m_ctl >> (2*n)) & 1) && ((m_ctl >> (2*n+1)) & 1))) ce |= (1 << n);
    chk("R1 R4 ale", int'(nand_ale), int'(m_active && m_kind == 2));
    chk("R2 R3 cle", int'(nand_cle), int'(m_active && m_kind == 1));
    chk("R7 we_n", int'(nand_we_n), int'(!(m_active && m_k >= 1 && m_k <= m_len)));
    chk("R7 dq_oe", int'(nand_dq_oe), int'(m_active));
    if (m_active) chk("R7 dout", int'(nand_dout), m_data);
    chk("R8 busy", int'(host_busy), int'(m_active));
    chk("R9 ready", int'(host_ready), m_rb2);
    chk("R5 R6 ce_n", int'(nand_ce_n), ce);
    chk("R5 ctl_q", int'(ctl_q), m_ctl);
    chk("R10 rdata", int'(bank_rdata), int'(nand_din));
  end

  task automatic bwrite(input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [LW-1:0] len, input int hold);
    @(negedge clk);
    bank_addr = a; bank_wdata = d; strobe_len = len; bank_wr = 1;
    repeat (hold) @(negedge clk);
    bank_wr = 0;
    repeat (len + 4) @(negedge clk);
  endtask

  task automatic cwrite(input logic [2*NCHIP-1:0] v);
    @(negedge clk);
    ctl_wdata = v; ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    bwrite(17'h10000, 8'hA5, 4'd3, 1);
    bwrite(17'h08000, 8'h3C, 4'd1, 1);
    bwrite(17'h00000, 8'h5A, 4'd0, 1);
    bwrite(17'h18000, 8'hC3, 4'd2, 1);
    bwrite(17'h08123, 8'h11, 4'd15, 1);
    bwrite(17'h10000, 8'h77, 4'd2, 9);
    cwrite(8'b0000_0001);
    cwrite(8'b0000_0011);
    cwrite(8'b1100_1110);
    cwrite(8'hFF);
    cwrite(8'h00);
    fork
      bwrite(17'h00004, 8'h9E, 4'd5, 1);
      begin repeat (3) @(negedge clk); cwrite(8'b0011_0000); cwrite(8'h00); end
    join
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nand_rb = ($urandom % 2) != 0;
      nand_din = 8'($urandom);
    end
    for (int i = 0; i < 6; i++)
      bwrite(17'($urandom), 8'($urandom), 4'($urandom), 1 + ($urandom % 6));
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    done = 1;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule